// File: doc/BRIEF.md
# Upgrade Register Serial Access Port

This block gives user logic a serial path into the reconfiguration registers. Data moves one bit per rising edge of a user clock through a 26-bit shift register. Two select inputs choose the action for each edge: shift a bit in, capture the register contents for read-back, or load a new update word. The serial output always shows the most significant bit of the shift register.

The block holds a 21-bit update register and a 21-bit control register. A 5-bit status word comes in from outside. Whether a load may reach the update register depends on two things: the operating mode (remote or local) and the image flag, which tells a factory image from an application image. When the core reconfiguration request rises, the update register is copied into the control register. In local mode that copy never happens.

The control register word has this layout: bit 0 is the image flag, bits 7:1 are the page number (bits 3:1 hold the low three page bits and bits 7:4 the high four), bit 8 enables the watchdog, and bits 20:9 hold the watchdog timeout. The decoded fields are driven out on their own ports.

Top module: `upg_serial_port`

## Requirements
- R1: While reset is held, the shift and update registers clear to zero. The control register resets to 0x000000 in remote mode (remote_i=1) and to 0x000002 in local mode (remote_i=0), which is page 1 in local mode. After reset, sdo_o is 0.
- R2: With shift_i=1, each rising edge shifts the shift register left by one and puts sdi_i into bit 0. capture_i has no effect while shift_i=1.
- R3: With shift_i=0 and capture_i=1, a rising edge loads the shift register with {status_i[4:0], word}. The word is the update register when anf_i=0 (factory image) and the control register when anf_i=1 (application image).
- R4: With shift_i=0 and capture_i=0, a rising edge copies shift register bits 20:0 into the update register. This happens only when remote_i=1 and anf_i=0. In every other case the update register and the shift register keep their values.
- R5: In local mode (remote_i=0) the control register keeps its reset value. Neither loads nor reconfiguration requests change it.
- R6: In remote mode, on the first edge where reconfig_i is sampled high after it was sampled low, the control register takes the value the update register held before that edge. While reconfig_i stays high, or stays low, the control register does not change.
- R7: sdo_o equals bit 25 of the shift register. It shows a new bit after each rising edge that changes the shift register, and it is unchanged by a load.
- R8: page_o equals control bits 7:1, with page bits 2:0 taken from control bits 3:1 and page bits 6:3 from control bits 7:4. wdt_en_o equals control bit 8, and wdt_timeout_o equals control bits 20:9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | User clock; every action happens on its rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| sdi_i | input | 1 | Serial data into the shift register |
| shift_i | input | 1 | 1 = shift, 0 = capture or load |
| capture_i | input | 1 | When not shifting: 1 = capture, 0 = load |
| remote_i | input | 1 | 1 = remote mode, 0 = local mode |
| anf_i | input | 1 | 1 = application image, 0 = factory image |
| reconfig_i | input | 1 | Core reconfiguration request; acts on its rising edge |
| status_i | input | 5 | Status word, read in during a capture |
| sdo_o | output | 1 | Serial data out (shift register MSB) |
| ctrl_o | output | 21 | Control register contents |
| page_o | output | 7 | Decoded page number |
| wdt_en_o | output | 1 | Decoded watchdog enable |
| wdt_timeout_o | output | 12 | Decoded watchdog timeout |

## Verification
The assertions assume that remote_i changes only while reset is held. The bench drives the mode only inside its reset task, so this holds throughout. The edge properties also assume that reconfig_i is low during reset, and the bench keeps it low there. In the random phases, status_i, anf_i and the select inputs vary freely, so every action is exercised under both image types.

// File: rtl/upg_pkg.sv
package upg_pkg;

   // Action taken on one user-clock edge
   typedef enum logic [1:0] {
      OP_LOAD    = 2'd0,
      OP_CAPTURE = 2'd1,
      OP_SHIFT   = 2'd2
   } upg_op_e;

   // Shift wins over capture; otherwise capture picks capture or load
   function automatic upg_op_e decode_op(input logic shift, input logic capture);
      if (shift)        return OP_SHIFT;
      else if (capture) return OP_CAPTURE;
      else              return OP_LOAD;
   endfunction

endpackage

// File: rtl/upg_shift_path.sv
module upg_shift_path
   import upg_pkg::*;
#(
   parameter int CTRL_W = 21,
   parameter int STAT_W = 5,
   localparam int SR_W  = CTRL_W + STAT_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  upg_op_e           op_i,
   input  logic              sdi_i,
   input  logic              anf_i,
   input  logic [STAT_W-1:0] status_i,
   input  logic [CTRL_W-1:0] upd_i,
   input  logic [CTRL_W-1:0] ctrl_i,
   output logic [SR_W-1:0]   sr_o,
   output logic              sdo_o
);

   logic [SR_W-1:0]   sr_q;
   logic [CTRL_W-1:0] cap_word;

   // The image type picks which register is read back
   always_comb cap_word = anf_i ? ctrl_i : upd_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sr_q <= '0;
      end else begin
         case (op_i)
            OP_SHIFT:   sr_q <= {sr_q[SR_W-2:0], sdi_i};
            OP_CAPTURE: sr_q <= {status_i, cap_word};
            default:    sr_q <= sr_q;
         endcase
      end
   end

   assign sr_o  = sr_q;
   assign sdo_o = sr_q[SR_W-1];

endmodule

// File: rtl/upg_update_reg.sv
module upg_update_reg
   import upg_pkg::*;
#(
   parameter int CTRL_W = 21
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  upg_op_e           op_i,
   input  logic              remote_i,
   input  logic              anf_i,
   input  logic [CTRL_W-1:0] sr_low_i,
   output logic [CTRL_W-1:0] upd_o
);

   logic              wr_ok;
   logic [CTRL_W-1:0] upd_q;

   // Only a factory image in remote mode may write
   always_comb wr_ok = remote_i & ~anf_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                          upd_q <= '0;
      else if (op_i == OP_LOAD && wr_ok)    upd_q <= sr_low_i;
   end

   assign upd_o = upd_q;

endmodule

// File: rtl/upg_ctrl_reg.sv
module upg_ctrl_reg #(
   parameter int CTRL_W     = 21,
   parameter int LOCAL_PAGE = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              remote_i,
   input  logic              reconfig_i,
   input  logic [CTRL_W-1:0] upd_i,
   output logic [CTRL_W-1:0] ctrl_o
);

   localparam logic [CTRL_W-1:0] LOCAL_RST = CTRL_W'(LOCAL_PAGE << 1);

   logic              req_d;
   logic              req_rise;
   logic [CTRL_W-1:0] ctrl_q;

   always_comb req_rise = reconfig_i & ~req_d;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) req_d <= 1'b0;
      else         req_d <= reconfig_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                   ctrl_q <= remote_i ? '0 : LOCAL_RST;
      else if (remote_i && req_rise) ctrl_q <= upd_i;
   end

   assign ctrl_o = ctrl_q;

endmodule

// File: rtl/upg_field_decode.sv
module upg_field_decode #(
   parameter int PAGE_LO_W = 3,
   parameter int PAGE_HI_W = 4,
   parameter int WDT_W     = 12,
   localparam int PAGE_W   = PAGE_LO_W + PAGE_HI_W,
   localparam int CTRL_W   = 2 + PAGE_W + WDT_W
) (
   input  logic [CTRL_W-1:0] ctrl_i,
   output logic [PAGE_W-1:0] page_o,
   output logic              wdt_en_o,
   output logic [WDT_W-1:0]  wdt_timeout_o
);

   localparam int LO_BASE  = 1;
   localparam int HI_BASE  = LO_BASE + PAGE_LO_W;
   localparam int EN_BIT   = HI_BASE + PAGE_HI_W;
   localparam int WDT_BASE = EN_BIT + 1;

   for (genvar i = 0; i < PAGE_LO_W; i++) begin : g_page_lo
      assign page_o[i] = ctrl_i[LO_BASE+i];
   end

   for (genvar j = 0; j < PAGE_HI_W; j++) begin : g_page_hi
      assign page_o[PAGE_LO_W+j] = ctrl_i[HI_BASE+j];
   end

   assign wdt_en_o      = ctrl_i[EN_BIT];
   assign wdt_timeout_o = ctrl_i[WDT_BASE +: WDT_W];

endmodule

// File: rtl/upg_serial_port.sv
module upg_serial_port
   import upg_pkg::*;
#(
   parameter int PAGE_LO_W  = 3,
   parameter int PAGE_HI_W  = 4,
   parameter int WDT_W      = 12,
   parameter int STAT_W     = 5,
   parameter int LOCAL_PAGE = 1,
   localparam int PAGE_W    = PAGE_LO_W + PAGE_HI_W,
   localparam int CTRL_W    = 2 + PAGE_W + WDT_W,
   localparam int SR_W      = CTRL_W + STAT_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sdi_i,
   input  logic              shift_i,
   input  logic              capture_i,
   input  logic              remote_i,
   input  logic              anf_i,
   input  logic              reconfig_i,
   input  logic [STAT_W-1:0] status_i,
   output logic              sdo_o,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic [PAGE_W-1:0] page_o,
   output logic              wdt_en_o,
   output logic [WDT_W-1:0]  wdt_timeout_o
);

   // Elaboration-time parameter checks
   if (PAGE_LO_W < 1 || PAGE_HI_W < 0) begin : g_bad_page
      $error("upg_serial_port: page segment widths out of range");
   end
   if (WDT_W < 1 || STAT_W < 1) begin : g_bad_width
      $error("upg_serial_port: watchdog and status widths must be positive");
   end
   if (LOCAL_PAGE < 0 || LOCAL_PAGE >= (1 << PAGE_W)) begin : g_bad_local
      $error("upg_serial_port: LOCAL_PAGE does not fit the page field");
   end

   upg_op_e           op;
   logic [SR_W-1:0]   sr_q;
   logic [CTRL_W-1:0] upd_q;
   logic [CTRL_W-1:0] ctrl_q;

   always_comb op = decode_op(shift_i, capture_i);

   upg_shift_path #(
      .CTRL_W (CTRL_W),
      .STAT_W (STAT_W)
   ) u_shift (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .op_i     (op),
      .sdi_i    (sdi_i),
      .anf_i    (anf_i),
      .status_i (status_i),
      .upd_i    (upd_q),
      .ctrl_i   (ctrl_q),
      .sr_o     (sr_q),
      .sdo_o    (sdo_o)
   );

   upg_update_reg #(
      .CTRL_W (CTRL_W)
   ) u_upd (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .op_i     (op),
      .remote_i (remote_i),
      .anf_i    (anf_i),
      .sr_low_i (sr_q[CTRL_W-1:0]),
      .upd_o    (upd_q)
   );

   upg_ctrl_reg #(
      .CTRL_W     (CTRL_W),
      .LOCAL_PAGE (LOCAL_PAGE)
   ) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .remote_i   (remote_i),
      .reconfig_i (reconfig_i),
      .upd_i      (upd_q),
      .ctrl_o     (ctrl_q)
   );

   upg_field_decode #(
      .PAGE_LO_W (PAGE_LO_W),
      .PAGE_HI_W (PAGE_HI_W),
      .WDT_W     (WDT_W)
   ) u_dec (
      .ctrl_i        (ctrl_q),
      .page_o        (page_o),
      .wdt_en_o      (wdt_en_o),
      .wdt_timeout_o (wdt_timeout_o)
   );

   assign ctrl_o = ctrl_q;

endmodule

// File: rtl/upg_serial_port_chk.sv
module upg_serial_port_chk #(
   parameter int CTRL_W = 21,
   parameter int STAT_W = 5,
   localparam int SR_W  = CTRL_W + STAT_W
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              sdi_i,
   input logic              shift_i,
   input logic              capture_i,
   input logic              remote_i,
   input logic              anf_i,
   input logic              reconfig_i,
   input logic [STAT_W-1:0] status_i,
   input logic              sdo_o,
   input logic [SR_W-1:0]   sr_q,
   input logic [CTRL_W-1:0] upd_q,
   input logic [CTRL_W-1:0] ctrl_q
);

   p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i |=> sr_q == {$past(sr_q[SR_W-2:0]), $past(sdi_i)});

   p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!shift_i && capture_i) |=>
         sr_q == {$past(status_i), ($past(anf_i) ? $past(ctrl_q) : $past(upd_q))});

   p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!shift_i && !capture_i && remote_i && !anf_i) |=>
         upd_q == $past(sr_q[CTRL_W-1:0]));

   p_no_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(!shift_i && !capture_i && remote_i && !anf_i) |=> $stable(upd_q));

   p_local_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !remote_i |=> $stable(ctrl_q));

   p_reconf_copy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (remote_i && $rose(reconfig_i)) |=> ctrl_q == $past(upd_q));

   p_reconf_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$rose(reconfig_i) |=> $stable(ctrl_q));

   p_sdo_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!shift_i && !capture_i) |=> $stable(sdo_o));

endmodule

bind upg_serial_port upg_serial_port_chk #(
   .CTRL_W (CTRL_W),
   .STAT_W (STAT_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .sdi_i      (sdi_i),
   .shift_i    (shift_i),
   .capture_i  (capture_i),
   .remote_i   (remote_i),
   .anf_i      (anf_i),
   .reconfig_i (reconfig_i),
   .status_i   (status_i),
   .sdo_o      (sdo_o),
   .sr_q       (sr_q),
   .upd_q      (upd_q),
   .ctrl_q     (ctrl_q)
);

// File: tb/upg_serial_port_tb_top.sv
module upg_serial_port_tb_top;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        sdi_i = 1'b0, shift_i = 1'b0, capture_i = 1'b0;
   logic        remote_i = 1'b1, anf_i = 1'b0, reconfig_i = 1'b0;
   logic [4:0]  status_i = 5'h15;
   logic        sdo_o;
   logic [20:0] ctrl_o;
   logic [6:0]  page_o;
   logic        wdt_en_o;
   logic [11:0] wdt_timeout_o;

   int n_cmp = 0;
   int n_bad = 0;

   // Reference model, built from the requirements
   logic [25:0] m_sr;
   logic [20:0] m_upd, m_ctrl;
   logic        m_prev;

   always #4 clk_i = ~clk_i;

   upg_serial_port dut_i (
      .clk_i, .rst_ni, .sdi_i, .shift_i, .capture_i, .remote_i, .anf_i,
      .reconfig_i, .status_i, .sdo_o, .ctrl_o, .page_o, .wdt_en_o, .wdt_timeout_o
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [25:0] cap_word(input logic [4:0] st, input logic anf,
                                            input logic [20:0] ctl, input logic [20:0] upd);
      return {st, anf ? ctl : upd};
   endfunction

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic do_reset(input logic mode);
      rst_ni = 1'b0; remote_i = mode;
      shift_i = 0; capture_i = 0; sdi_i = 0; reconfig_i = 0;
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      m_sr = '0; m_upd = '0; m_ctrl = mode ? 21'h0 : 21'h2; m_prev = 1'b0;
   endtask

   // One clock: drive at the falling edge, model the rising edge, check at the next falling edge
   task automatic step(input logic sh, input logic cap, input logic din, input logic rc);
      logic [20:0] old_upd;
      shift_i = sh; capture_i = cap; sdi_i = din; reconfig_i = rc;
      @(posedge clk_i);
      old_upd = m_upd;
      if (sh)                      m_sr = {m_sr[24:0], din};
      else if (cap)                m_sr = cap_word(status_i, anf_i, m_ctrl, m_upd);
      else if (remote_i && !anf_i) m_upd = m_sr[20:0];
      if (remote_i && rc && !m_prev) m_ctrl = old_upd;
      m_prev = rc;
      @(negedge clk_i);
      chk("R7 serial out", 32'(sdo_o), 32'(m_sr[25]));
      chk("R6/R5 control", 32'(ctrl_o), 32'(m_ctrl));
   endtask

   task automatic write_word(input logic [25:0] w, input logic cap);
      for (int i = 25; i >= 0; i--) step(1'b1, cap, w[i], 1'b0);
   endtask

   task automatic shift_out(output logic [25:0] got);
      for (int i = 25; i >= 0; i--) begin
         got[i] = sdo_o;
         step(1'b1, 1'b0, 1'b0, 1'b0);
      end
   endtask

   task automatic read_word(output logic [25:0] got);
      step(1'b0, 1'b1, 1'b0, 1'b0);
      shift_out(got);
   endtask

   task automatic pulse_reconf();
      step(1'b0, 1'b1, 1'b0, 1'b1);
      step(1'b0, 1'b1, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [25:0] got;
      logic [20:0] w1, w2;
      void'($urandom(32'd4242));

      // R1: reset state, remote mode
      do_reset(1'b1);
      chk("R1 sdo after reset", 32'(sdo_o), 32'd0);
      chk("R1 remote ctrl reset", 32'(ctrl_o), 32'h0);
      chk("R8 page at reset", 32'(page_o), 32'd0);

      // R4: factory image in remote mode loads; R3: capture reads update
      anf_i = 1'b0;
      w1 = 21'h1A5C3B;
      write_word({5'h0, w1}, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      read_word(got);
      chk("R3/R4 factory capture", 32'(got), 32'(cap_word(status_i, 1'b0, m_ctrl, w1)));

      // R6: rising request copies update into control; R8 fields
      pulse_reconf();
      chk("R6 copy on rise", 32'(ctrl_o), 32'(w1));
      chk("R8 page", 32'(page_o), 32'({w1[7:4], w1[3:1]}));
      chk("R8 wdt enable", 32'(wdt_en_o), 32'(w1[8]));
      chk("R8 wdt timeout", 32'(wdt_timeout_o), 32'(w1[20:9]));

      // R6: request held high does not copy again
      w2 = 21'h0F0F0F;
      write_word({5'h0, w2}, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0, 1'b1);
      step(1'b0, 1'b0, 1'b0, 1'b1);
      step(1'b0, 1'b0, 1'b0, 1'b1);
      chk("R6 held high no recopy", 32'(ctrl_o), 32'(w2));
      write_word({5'h0, 21'h155555}, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b1);
      step(1'b0, 1'b1, 1'b0, 1'b1);
      chk("R6 still held", 32'(ctrl_o), 32'(w2));
      step(1'b0, 1'b1, 1'b0, 1'b0);

      // R4: application image cannot load; R3: capture reads control
      anf_i = 1'b1;
      write_word({5'h1F, 21'h0ABCDE}, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      read_word(got);
      chk("R3 application capture", 32'(got), 32'(cap_word(status_i, 1'b1, w2, 21'h0)));
      anf_i = 1'b0;
      read_word(got);
      chk("R4 application load ignored", 32'(got[20:0]), 32'(21'h155555));

      // R2: capture ignored while shifting
      write_word(26'h2D3C4B5, 1'b1);
      shift_out(got);
      chk("R2 shift ignores capture", 32'(got), 32'h2D3C4B5);

      // Random phase, remote mode
      for (int c = 0; c < 3000; c++) begin
         if (c % 64 == 0) anf_i = 1'($urandom_range(0, 1));
         status_i = 5'($urandom);
         step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0));
      end

      // Local mode: R1 reset value, R5 control never written
      do_reset(1'b0);
      anf_i = 1'b0;
      status_i = 5'h0A;
      chk("R1 local ctrl reset", 32'(ctrl_o), 32'h2);
      chk("R8 local page", 32'(page_o), 32'd1);
      write_word({5'h0, 21'h1FFFFF}, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      read_word(got);
      chk("R4/R5 local load ignored", 32'(got), 32'(cap_word(5'h0A, 1'b0, 21'h2, 21'h0)));
      pulse_reconf();
      chk("R5 local reconfig ignored", 32'(ctrl_o), 32'h2);
      anf_i = 1'b1;
      read_word(got);
      chk("R3 local application capture", 32'(got), 32'(cap_word(5'h0A, 1'b1, 21'h2, 21'h0)));

      for (int c = 0; c < 1000; c++) begin
         if (c % 50 == 0) anf_i = 1'($urandom_range(0, 1));
         status_i = 5'($urandom);
         step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0));
      end
      chk("R5 local ctrl after random", 32'(ctrl_o), 32'h2);

      finish_run();
   end

endmodule